// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into host memory under the control of a list of 16-byte descriptors that software places in that memory. For each descriptor it reads four 32-bit words, checks that the engine owns the entry, and picks one of two buffer fields. It then copies as much of the pending frame as fits into that buffer through a word-wide memory port with byte strobes, and writes a status word back over word 0, which hands the entry back to software. A frame larger than one buffer spreads over several descriptors, with first and last segment marks telling software where the frame starts and ends.

Frames arrive on a byte stream with the frame length presented up front. The engine pulls one byte per cycle while copying and signals when the frame is fully consumed. The following descriptor comes from one of three rules: wrap to the list base, follow a chain pointer, or step 16 bytes forward. When the engine meets a descriptor it does not own, it reports "no descriptor available" and waits for a poll pulse or a new list base. The run enable is sampled only between descriptors, so turning it off never cuts a status write short.

Memory reads have a fixed latency of one cycle: the word for an address presented with `mem_req` high and `mem_we` low is on `mem_rdata` in the next cycle. Buffer pointers are treated as word aligned, and their two low bits are ignored.

Top module: `rx_desc_engine`

## Requirements
- R1: After reset, `mem_req`, `frame_pop`, `frame_done`, `rx_int`, `rx_unavail` and `rx_suspended` are all low.
- R2: A descriptor is fetched only while `rx_enable` is high, the engine is not suspended, and a frame is pending or partly received. The fetch reads word 0 at the current pointer, then the words at +4, +8 and +12, and the engine owns the entry when bit 31 of word 0 is 1.
- R3: On reading word 0 with bit 31 clear, `rx_unavail` pulses for one cycle and `rx_suspended` rises. No further memory access happens until `rx_poll` or `list_load` clears it, after which the same descriptor is fetched again.
- R4: When the buffer-1 size (word 1 bits 10:0) is nonzero, it is used with the pointer in word 2. Otherwise the buffer-2 size (word 1 bits 21:11) is used with the pointer in word 3.
- R5: The engine copies the smaller of the remaining frame bytes and the buffer size. Bytes go out as little-endian 32-bit writes at ascending word addresses from the buffer start: frame byte k of the segment lands in byte lane k mod 4, and `mem_be` marks exactly the lanes written.
- R6: After the data writes of a descriptor, exactly one full-word write of the status goes to word 0. Bit 31 is 0, bit 9 (first segment) is set when the segment starts at frame offset 0, and bit 8 (last segment) is set when the segment ends the frame. All other bits are zero unless R7 sets them.
- R7: On the last segment, status bits 29:16 hold the frame length plus 4 and bit 7 is set when the frame length exceeds 1518. `rx_int` and `frame_done` pulse in the cycle of that status write.
- R8: The next descriptor pointer is the list base when word 1 bit 25 is set. Otherwise it is word 3 with its low two bits cleared when word 1 bit 24 is set, and otherwise the current pointer plus 16.
- R9: A `list_load` pulse stores `list_base` with its low two bits forced to zero as both the list base and the current descriptor pointer.
- R10: Dropping `rx_enable` while a descriptor is in progress lets that descriptor finish, including its status write. No memory access follows until `rx_enable` returns high, and the frame then continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Run enable, sampled between descriptors |
| rx_poll | input | 1 | Pulse: clear the suspended state and retry |
| list_load | input | 1 | Pulse: load the list base and current pointer |
| list_base | input | 32 | Byte address of the first descriptor |
| frame_avail | input | 1 | A frame is waiting at the byte stream |
| frame_len | input | LEN_W | Length in bytes of the waiting frame, without CRC |
| frame_byte | input | 8 | Current byte of the frame (show-ahead) |
| frame_pop | output | 1 | Consume the current byte |
| frame_done | output | 1 | Pulse: the frame has been fully consumed |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| rx_int | output | 1 | Pulse: a frame has been completely stored |
| rx_unavail | output | 1 | Pulse: the current descriptor was not owned |
| rx_suspended | output | 1 | Engine is waiting for a poll after a non-owned descriptor |

## Verification
The patterns used are a short frame that is not a multiple of four bytes in one large buffer, which checks partial byte strobes and the first/last marks on a single segment, and a frame spread over a buffer-2-only entry, a chained entry and an end-of-ring entry, which separates the three next-pointer rules and the two buffer selections. The wrap back onto an entry already returned to the host exercises the not-owned stall and its resume by poll. A 1600-byte frame in a 2047-byte buffer checks the too-long flag and the CRC-inclusive length. A misaligned list base and an enable dropped mid-segment tell apart pointer alignment and the stop-at-boundary rule from normal running.

// File: rtl/rxd_pkg.sv
// Shared definitions for the receive descriptor engine: descriptor field
// positions and the controller state encoding.
// Assumes descriptors of four 32-bit little-endian words.
package rxd_pkg;
    localparam int WORD_W    = 32;
    localparam int OWN_BIT   = 31;  // word 0: engine owns the entry
    localparam int FL_LSB    = 16;  // word 0: frame length field
    localparam int FL_W      = 14;
    localparam int FS_BIT    = 9;   // word 0: first segment
    localparam int LS_BIT    = 8;   // word 0: last segment
    localparam int TL_BIT    = 7;   // word 0: frame too long
    localparam int SZ_W      = 11;  // word 1: size field width
    localparam int SZ2_LSB   = 11;  // word 1: buffer-2 size position
    localparam int CH_BIT    = 24;  // word 1: chained
    localparam int ER_BIT    = 25;  // word 1: end of ring
    localparam int DESC_STEP = 16;  // bytes per descriptor

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_RD4,
        ST_SETUP, ST_COPY, ST_WB
    } rxd_state_e;
endpackage

// File: rtl/rxd_decode.sv
// Descriptor decoder: selects the buffer and its size, sizes the segment
// to copy and computes the next descriptor address.
// Assumes LEN_W >= the size field width; pointers are word aligned.
module rxd_decode
    import rxd_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic [WORD_W-1:0] cur_addr,
    input  logic [WORD_W-1:0] base_addr,
    input  logic [WORD_W-1:0] ctl_word,
    input  logic [WORD_W-1:0] ptr1_word,
    input  logic [WORD_W-1:0] ptr2_word,
    input  logic [LEN_W-1:0]  remaining,
    output logic [WORD_W-1:0] buf_addr,
    output logic [WORD_W-1:0] next_addr,
    output logic [LEN_W-1:0]  seg_len
);
    logic [SZ_W-1:0]   size_a;
    logic [SZ_W-1:0]   size_b;
    logic              use_a;
    logic [LEN_W-1:0]  size_sel;
    logic [WORD_W-1:0] ptr_sel;

    // Buffer choice and segment length
    always_comb begin
        size_a   = ctl_word[SZ_W-1:0];
        size_b   = ctl_word[SZ2_LSB +: SZ_W];
        use_a    = (size_a != '0);
        size_sel = use_a ? LEN_W'(size_a) : LEN_W'(size_b);
        ptr_sel  = use_a ? ptr1_word : ptr2_word;
        buf_addr = {ptr_sel[WORD_W-1:2], 2'b00};
        seg_len  = (remaining < size_sel) ? remaining : size_sel;
    end

    // Next-descriptor rule: ring end, then chain, then sequential
    always_comb begin
        if (ctl_word[ER_BIT])
            next_addr = base_addr;
        else if (ctl_word[CH_BIT])
            next_addr = {ptr2_word[WORD_W-1:2], 2'b00};
        else
            next_addr = cur_addr + WORD_W'(DESC_STEP);
    end
endmodule

// File: rtl/rxd_status.sv
// Status word builder: forms the word written back over descriptor word 0.
// Ownership is always returned (bit 31 zero).
module rxd_status
    import rxd_pkg::*;
#(
    parameter int LEN_W        = 14,
    parameter int MAX_DATA_LEN = 1518,
    parameter int CRC_LEN      = 4
) (
    input  logic              first_seg,
    input  logic              last_seg,
    input  logic [LEN_W-1:0]  frame_len,
    output logic [WORD_W-1:0] status
);
    logic [WORD_W-1:0] total_len;

    // Assemble segment flags and, on the last segment, length and size error
    always_comb begin
        total_len = WORD_W'(frame_len) + WORD_W'(CRC_LEN);
        status    = '0;
        status[FS_BIT] = first_seg;
        status[LS_BIT] = last_seg;
        if (last_seg) begin
            status[FL_LSB +: FL_W] = total_len[FL_W-1:0];
            status[TL_BIT]         = (WORD_W'(frame_len) > WORD_W'(MAX_DATA_LEN));
        end
    end
endmodule

// File: rtl/rxd_packer.sv
// Byte-to-word packer: gathers a byte stream into little-endian words and
// issues one strobed write per buffer word.
// Assumes the buffer start is word aligned and one byte arrives per push.
module rxd_packer
    import rxd_pkg::*;
#(
    parameter int IDX_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] base_addr,
    input  logic              push,
    input  logic              flush,
    input  logic [7:0]        din,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [3:0]        wr_be
);
    logic [1:0]        lane;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] acc;
    logic [3:0]        mask;

    // Merge the incoming byte into the partly filled word
    always_comb begin
        wr_data = acc;
        wr_data[8*lane +: 8] = din;
        wr_be   = mask | (4'b0001 << lane);
        wr_en   = push && (lane == 2'd3 || flush);
        wr_addr = base_addr + {{(WORD_W-IDX_W-2){1'b0}}, word_idx, 2'b00};
    end

    // Track lane, word index and the partial word
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            lane     <= '0;
            word_idx <= '0;
            acc      <= '0;
            mask     <= '0;
        end else if (push) begin
            lane <= lane + 2'd1;
            if (wr_en) begin
                acc      <= '0;
                mask     <= '0;
                word_idx <= word_idx + 1'b1;
            end else begin
                acc  <= wr_data;
                mask <= wr_be;
            end
        end
    end

    // R5: every word write starts at lane 0 of an aligned buffer
    p_write_lane0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_be[0]);
endmodule

// File: rtl/rx_desc_engine.sv
// Receive descriptor ring engine: fetches descriptors, copies frame bytes
// into the selected buffer and writes status back over word 0.
// Assumes memory read data one cycle after a read request, a show-ahead
// byte source that never stalls inside a frame, and list_load while idle.
module rx_desc_engine
    import rxd_pkg::*;
#(
    parameter int LEN_W        = 14,
    parameter int MAX_DATA_LEN = 1518,
    parameter int CRC_LEN      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              rx_poll,
    input  logic              list_load,
    input  logic [31:0]       list_base,
    input  logic              frame_avail,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [7:0]        frame_byte,
    output logic              frame_pop,
    output logic              frame_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [31:0]       mem_rdata,
    output logic              rx_int,
    output logic              rx_unavail,
    output logic              rx_suspended
);
    rxd_state_e        state;
    logic [WORD_W-1:0] cur_addr, base_addr;
    logic [WORD_W-1:0] ctl_q, ptr1_q, ptr2_q;
    logic [WORD_W-1:0] buf_q, next_q;
    logic [LEN_W-1:0]  flen_q, offset, seg_q, cnt;
    logic              in_frame, first_q, last_q, suspended;

    logic [WORD_W-1:0] dec_buf, dec_next, stat_word;
    logic [LEN_W-1:0]  dec_seg, remaining;
    logic              pk_wr;
    logic [WORD_W-1:0] pk_addr, pk_data;
    logic [3:0]        pk_be;
    logic              seg_end;

    assign remaining = flen_q - offset;
    assign seg_end   = (cnt == seg_q - 1'b1);

    rxd_decode #(.LEN_W(LEN_W)) u_decode (
        .cur_addr (cur_addr),
        .base_addr(base_addr),
        .ctl_word (ctl_q),
        .ptr1_word(ptr1_q),
        .ptr2_word(ptr2_q),
        .remaining(remaining),
        .buf_addr (dec_buf),
        .next_addr(dec_next),
        .seg_len  (dec_seg)
    );

    rxd_status #(.LEN_W(LEN_W), .MAX_DATA_LEN(MAX_DATA_LEN), .CRC_LEN(CRC_LEN)) u_status (
        .first_seg(first_q),
        .last_seg (last_q),
        .frame_len(flen_q),
        .status   (stat_word)
    );

    rxd_packer #(.IDX_W(LEN_W)) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (state == ST_SETUP),
        .base_addr(buf_q),
        .push     (state == ST_COPY),
        .flush    (seg_end),
        .din      (frame_byte),
        .wr_en    (pk_wr),
        .wr_addr  (pk_addr),
        .wr_data  (pk_data),
        .wr_be    (pk_be)
    );

    // Controller: fetch, decode, copy and write-back sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            base_addr <= '0;
            ctl_q     <= '0;
            ptr1_q    <= '0;
            ptr2_q    <= '0;
            buf_q     <= '0;
            next_q    <= '0;
            flen_q    <= '0;
            offset    <= '0;
            seg_q     <= '0;
            cnt       <= '0;
            in_frame  <= 1'b0;
            first_q   <= 1'b0;
            last_q    <= 1'b0;
            suspended <= 1'b0;
        end else begin
            case (state)
                ST_IDLE:
                    if (rx_enable && !suspended && (in_frame || frame_avail))
                        state <= ST_RD0;
                ST_RD0: state <= ST_RD1;
                ST_RD1:
                    if (mem_rdata[OWN_BIT]) begin
                        state <= ST_RD2;
                    end else begin
                        state     <= ST_IDLE;
                        suspended <= 1'b1;
                    end
                ST_RD2: begin
                    ctl_q <= mem_rdata;
                    state <= ST_RD3;
                end
                ST_RD3: begin
                    ptr1_q <= mem_rdata;
                    state  <= ST_RD4;
                end
                ST_RD4: begin
                    ptr2_q <= mem_rdata;
                    if (!in_frame) begin
                        flen_q   <= frame_len;
                        offset   <= '0;
                        in_frame <= 1'b1;
                    end
                    state <= ST_SETUP;
                end
                ST_SETUP: begin
                    seg_q   <= dec_seg;
                    buf_q   <= dec_buf;
                    next_q  <= dec_next;
                    first_q <= (offset == '0);
                    last_q  <= (dec_seg == remaining);
                    cnt     <= '0;
                    state   <= (dec_seg == '0) ? ST_WB : ST_COPY;
                end
                ST_COPY: begin
                    cnt    <= cnt + 1'b1;
                    offset <= offset + 1'b1;
                    if (seg_end)
                        state <= ST_WB;
                end
                ST_WB: begin
                    cur_addr <= next_q;
                    if (last_q) begin
                        in_frame <= 1'b0;
                        offset   <= '0;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (rx_poll)
                suspended <= 1'b0;
            if (list_load) begin
                base_addr <= {list_base[31:2], 2'b00};
                cur_addr  <= {list_base[31:2], 2'b00};
                suspended <= 1'b0;
            end
        end
    end

    // Memory port multiplexer: descriptor reads, buffer writes, status write
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        case (state)
            ST_RD0: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr;
            end
            ST_RD1: begin
                mem_req  = mem_rdata[OWN_BIT];
                mem_addr = cur_addr + 32'd4;
            end
            ST_RD2: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr + 32'd8;
            end
            ST_RD3: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr + 32'd12;
            end
            ST_COPY: begin
                mem_req   = pk_wr;
                mem_we    = pk_wr;
                mem_addr  = pk_addr;
                mem_wdata = pk_data;
                mem_be    = pk_be;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_addr;
                mem_wdata = stat_word;
                mem_be    = 4'hF;
            end
            default: ;
        endcase
    end

    // Status pulses and byte-stream handshake
    always_comb begin
        frame_pop    = (state == ST_COPY);
        rx_int       = (state == ST_WB) && last_q;
        frame_done   = rx_int;
        rx_unavail   = (state == ST_RD1) && !mem_rdata[OWN_BIT];
        rx_suspended = suspended;
    end

    // R9: every access uses a word-aligned address
    p_addr_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    // R3: a not-owned entry leaves the engine suspended unless cleared
    p_unavail_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_unavail && !rx_poll && !list_load) |=> rx_suspended);
    // R3: no memory traffic while suspended and idle
    p_suspend_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_suspended && state == ST_IDLE) |-> !mem_req);
    // R6: the status write always hands the entry back
    p_owner_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && state == ST_WB) |-> !mem_wdata[OWN_BIT]);
    // R7: the receive interrupt coincides with a last-segment status write
    p_int_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_int |-> (mem_we && mem_wdata[LS_BIT] && frame_done));
    // R10: no new descriptor access once idle with the enable low
    p_stop_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !rx_enable) |=> !mem_req);
endmodule

// File: tb/rx_desc_engine_bench.sv
module rx_desc_engine_bench;
    localparam int LEN_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_enable = 1'b0;
    logic              rx_poll = 1'b0;
    logic              list_load = 1'b0;
    logic [31:0]       list_base = '0;
    logic              frame_avail;
    logic [LEN_W-1:0]  frame_len;
    logic [7:0]        frame_byte;
    logic              frame_pop, frame_done;
    logic              mem_req, mem_we;
    logic [31:0]       mem_addr, mem_wdata;
    logic [3:0]        mem_be;
    logic [31:0]       mem_rdata = '0;
    logic              rx_int, rx_unavail, rx_suspended;

    always #10 clk = ~clk;   // 50 MHz

    rx_desc_engine #(.LEN_W(LEN_W)) u_rx_desc_engine (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_poll(rx_poll),
        .list_load(list_load), .list_base(list_base),
        .frame_avail(frame_avail), .frame_len(frame_len), .frame_byte(frame_byte),
        .frame_pop(frame_pop), .frame_done(frame_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
        .rx_int(rx_int), .rx_unavail(rx_unavail), .rx_suspended(rx_suspended)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        int          tag;
    } acc_t;

    acc_t        exp_q[$];
    logic [31:0] mem    [int unsigned];
    logic [31:0] shadow [int unsigned];
    int vectors = 0, fails = 0, cyc = 0;
    int got_int = 0, got_un = 0, exp_int = 0, exp_un = 0;
    int issued = 0, retired = 0, fptr = 0, fseed = 0, flen = 0;
    logic [31:0] m_cur = '0, m_base = '0;
    int m_off = 0, m_tag = 1;

    function automatic logic [7:0] fbyte(int s, int k);
        return 8'((s * 37 + k * 7 + k / 3) & 255);
    endfunction

    assign frame_avail = (issued != retired);
    assign frame_len   = LEN_W'(flen);
    assign frame_byte  = fbyte(fseed, fptr);

    // Memory model with one-cycle read latency, and frame byte source
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                logic [31:0] w;
                w = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                for (int j = 0; j < 4; j++)
                    if (mem_be[j]) w[8*j +: 8] = mem_wdata[8*j +: 8];
                mem[mem_addr] = w;
            end else begin
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            end
        end
        if (frame_done) begin
            retired <= retired + 1;
            fptr    <= 0;
        end else if (frame_pop) begin
            fptr <= fptr + 1;
        end
    end

    // Per-clock comparison of every memory access against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) begin
                vectors++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R2 unexpected access: actual we=%0b addr=%h expected none",
                             mem_we, mem_addr);
                end else begin
                    acc_t e;
                    logic [31:0] m;
                    e = exp_q.pop_front();
                    m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
                    if (mem_we !== e.we || mem_addr !== e.addr ||
                        (e.we && (mem_be !== e.be || (mem_wdata & m) !== (e.data & m)))) begin
                        fails++;
                        $display("FAIL R%0d access: actual we=%0b addr=%h data=%h be=%h expected we=%0b addr=%h data=%h be=%h",
                                 e.tag, mem_we, mem_addr, mem_wdata & m, mem_be,
                                 e.we, e.addr, e.data, e.be);
                    end
                end
            end
            if (rx_int) got_int++;
            if (rx_unavail) got_un++;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            finish_run();
        end
    end

    task automatic check(string req, int act, int expv, string what);
        vectors++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic put_word(logic [31:0] a, logic [31:0] v);
        mem[a] = v;
        shadow[a] = v;
    endtask

    function automatic logic [31:0] sh(logic [31:0] a);
        return shadow.exists(a) ? shadow[a] : 32'h0;
    endfunction

    task automatic push_acc(bit we, logic [31:0] a, logic [31:0] d, logic [3:0] be);
        acc_t e;
        e.we = we; e.addr = a; e.data = d; e.be = be; e.tag = m_tag;
        exp_q.push_back(e);
    endtask

    // Reference walk of the descriptor list for the current frame
    task automatic model_run(output bit done);
        done = 1'b0;
        for (int guard = 0; guard < 64; guard++) begin
            logic [31:0] w0, w1, w2, w3, bufa, nxt, st;
            int sz, seg, tot;
            bit first, last;
            push_acc(1'b0, m_cur, 32'h0, 4'h0);
            w0 = sh(m_cur);
            if (!w0[31]) begin
                exp_un++;
                return;
            end
            push_acc(1'b0, m_cur + 4, 32'h0, 4'h0);
            push_acc(1'b0, m_cur + 8, 32'h0, 4'h0);
            push_acc(1'b0, m_cur + 12, 32'h0, 4'h0);
            w1 = sh(m_cur + 4); w2 = sh(m_cur + 8); w3 = sh(m_cur + 12);
            if (w1[10:0] != 0) begin sz = int'(w1[10:0]);  bufa = w2; end
            else               begin sz = int'(w1[21:11]); bufa = w3; end
            bufa[1:0] = 2'b00;
            if (w1[25])      nxt = m_base;
            else if (w1[24]) nxt = {w3[31:2], 2'b00};
            else             nxt = m_cur + 16;
            seg = (flen - m_off < sz) ? flen - m_off : sz;
            for (int k = 0; k < seg; k += 4) begin
                logic [31:0] d;
                logic [3:0]  be;
                d = '0; be = '0;
                for (int j = 0; j < 4; j++)
                    if (k + j < seg) begin
                        d[8*j +: 8] = fbyte(fseed, m_off + k + j);
                        be[j] = 1'b1;
                    end
                push_acc(1'b1, bufa + 32'(k), d, be);
            end
            first = (m_off == 0);
            m_off += seg;
            last = (m_off >= flen);
            st = '0;
            st[9] = first;
            st[8] = last;
            if (last) begin
                tot = flen + 4;
                st[29:16] = 14'(tot);
                st[7] = (flen > 1518);
                exp_int++;
            end
            push_acc(1'b1, m_cur, st, 4'hF);
            shadow[m_cur] = st;
            m_cur = nxt;
            if (last) begin
                m_off = 0;
                done = 1'b1;
                return;
            end
        end
    endtask

    task automatic start_frame(int len, int seed);
        bit d;
        @(negedge clk);
        flen = len; fseed = seed;
        model_run(d);
        issued = issued + 1;
    endtask

    task automatic drain();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !frame_avail) break;
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic load_list(logic [31:0] a);
        @(negedge clk);
        list_base = a; list_load = 1'b1;
        @(negedge clk);
        list_load = 1'b0;
        m_base = {a[31:2], 2'b00};
        m_cur = m_base;
    endtask

    task automatic desc(logic [31:0] a, logic [31:0] w1, logic [31:0] w2, logic [31:0] w3);
        put_word(a, 32'h8000_0000);
        put_word(a + 4, w1);
        put_word(a + 8, w2);
        put_word(a + 12, w3);
    endtask

    initial begin
        bit d;
        repeat (4) @(negedge clk);
        // R1: outputs quiet in reset and just after release
        check("R1", int'(mem_req | frame_pop | rx_int | rx_unavail | rx_suspended | frame_done), 0,
              "outputs during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(mem_req | frame_pop | rx_int | rx_unavail | rx_suspended | frame_done), 0,
              "outputs after reset");
        load_list(32'h0000_1000);
        rx_enable = 1'b1;

        // R5 R6: 61-byte frame in one 128-byte buffer, sequential next
        m_tag = 5;
        desc(32'h1000, 32'd128, 32'h5000, 32'h0);
        start_frame(61, 1);
        drain();
        check("R6", got_int, exp_int, "interrupts after single segment frame");
        check("R5", exp_q.size(), 0, "pending accesses after single frame");

        // R4 R8: buffer-2 entry, chained entry, end-of-ring entry
        m_tag = 8;
        desc(32'h1010, 32'd40 << 11, 32'h0, 32'h3000);
        desc(32'h1020, 32'h0100_0000 | 32'd40, 32'h3100, 32'h1200);
        desc(32'h1200, 32'h0200_0000 | 32'd64, 32'h3200, 32'h0);
        start_frame(100, 2);
        drain();
        check("R4", got_int, exp_int, "interrupts after three segment frame");
        check("R8", exp_q.size(), 0, "pending accesses after ring walk");

        // R3: wrap lands on the entry already returned to software
        m_tag = 3;
        start_frame(1600, 5);
        repeat (30) @(negedge clk);
        check("R3", int'(rx_suspended), 1, "suspended after non-owned entry");
        check("R3", got_un, exp_un, "unavailable pulses");
        check("R3", exp_q.size(), 0, "accesses while suspended");
        // R7: 1600-byte frame in a 2047-byte buffer after poll
        m_tag = 7;
        desc(32'h1000, 32'd2047, 32'h8000, 32'h0);
        model_run(d);
        @(negedge clk);
        rx_poll = 1'b1;
        @(negedge clk);
        rx_poll = 1'b0;
        check("R3", int'(rx_suspended), 0, "suspended cleared by poll");
        drain();
        check("R7", got_int, exp_int, "interrupts after long frame");
        check("R7", exp_q.size(), 0, "pending accesses after long frame");

        // R9: misaligned list base
        m_tag = 9;
        load_list(32'h0000_2003);
        desc(32'h2000, 32'd16, 32'h4000, 32'h0);
        desc(32'h2010, 32'd64, 32'h4100, 32'h0);
        start_frame(61, 3);
        drain();
        check("R9", exp_q.size(), 0, "pending accesses after aligned reload");
        check("R9", got_int, exp_int, "interrupts after reload frame");

        // R10: enable dropped during the first of two segments
        m_tag = 10;
        desc(32'h2020, 32'd40, 32'h4200, 32'h0);
        desc(32'h2030, 32'd40, 32'h4300, 32'h0);
        start_frame(80, 4);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (frame_pop) break;
        end
        rx_enable = 1'b0;
        repeat (120) @(negedge clk);
        check("R10", exp_q.size(), 15, "accesses left when stopped");
        check("R10", got_int, exp_int - 1, "interrupts while stopped");
        rx_enable = 1'b1;
        drain();
        check("R10", exp_q.size(), 0, "pending accesses after restart");
        check("R10", got_int, exp_int, "interrupts after restart");
        check("R2", got_un, exp_un, "total unavailable pulses");
        finish_run();
    end
endmodule